// File: doc/BRIEF.md
# Sized Integer ALU with Registered Condition Flags

This block performs one integer operation per clock on operands that can be treated as 8, 16 or 32 bits wide. The caller supplies two source operands, a size code and an operation code. It receives the result as a combinational output, together with a strobe that says whether the operation produces a value to be stored. Four condition flags are kept in a small register inside the block: negative (N), zero (Z), overflow (V) and carry/borrow (C). That register loads the flag values of the current operation on a clock edge, but only while the flag-enable input is high.

The flag rules depend on the operation. Arithmetic sets V and C from the adder. The logical operations clear V and leave the stored C alone. Compare gives a signed less-than on N and an unsigned less-than on C. Every flag is taken at the selected operand width.

The two carry-chained operations read the stored C as their carry-in. A multi-word sum or difference is therefore built by issuing them back to back with the flag enable held high.

Top module: `int_alu_cc`

## Requirements
- R1: After reset, and before any load, all four flags (N, Z, V, C) read 0.
- R2: Size code 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Result bits above the selected width are 0. When a result is formed, N is its top bit at that width and Z is set when it is all zeros at that width.
- R3: Operation 0 (add) returns B+A truncated to the width. C is the carry out of the top bit. V is set when A and B have the same sign and the truncated sum has the other sign.
- R4: Operation 2 (subtract) returns B−A. C is set on a borrow out of the top bit. V is set when A and B differ in sign and the result's sign differs from B.
- R5: Operation 1 (add with carry, B+A+C) and operation 3 (subtract with borrow, B−A−C) use the stored C flag as carry-in. They always work at 32 bits, whatever the size code, and set C and V like R3 and R4.
- R6: Operation 4 returns B AND NOT A, operation 5 returns B OR A, and operation 6 returns B XOR A. For all three, V is cleared and C keeps its stored value.
- R7: Operation 7 (bit test) forms B AND A for the N and Z flags only. It clears V and keeps C. It writes nothing: the write strobe is 0 and the result reads 0.
- R8: Operation 8 (compare A with B) writes nothing. It sets N when A<B as signed values, Z when A=B, and C when A<B as unsigned values, and it clears V.
- R9: Operation 9 returns NOT A, with V cleared and C kept. Operation 10 returns 0−A: V is set only when A is the most negative value at the width (the result is then A itself), and C is set whenever A is nonzero.
- R10: Operation 11 (clear) writes 0 and sets N=0, Z=1 and V=0, with C kept.
- R11: Operation 12 returns A+1 and operation 13 returns A−1, with C and V set as for add and subtract respectively. Operation 14 (test) sets N and Z from A, clears V and C, and writes nothing.
- R12: The flags load only on a clock edge where flag enable is 1, and they hold otherwise. Operation 15 is a no-operation: the write strobe is 0, the result reads 0, and the flags hold even with flag enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the flag register |
| opnd_a | input | LONG_W | Operand A: addend, subtrahend, mask, compare source 1 or unary source |
| opnd_b | input | LONG_W | Operand B: augend, minuend, masked operand or compare source 2 |
| size_sel | input | 2 | Operand width code |
| op_sel | input | 4 | Operation code |
| flag_en | input | 1 | Flag register load enable |
| result | output | LONG_W | Zero-extended result, 0 when nothing is written |
| result_we | output | 1 | High when the operation produces a result to store |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_v | output | 1 | Stored overflow flag |
| flag_c | output | 1 | Stored carry/borrow flag |

## Verification
The hardest case to reach is the carry-chained pair. Its outcome depends on a C flag left behind by whatever ran earlier, and on the size code being overridden. The stimulus sweeps every operation under every size code, including the two codes that both mean 32 bits, and mixes in edge values such as the most negative number, all ones, zero and A equal to B. The bench keeps its own copy of the flag state and lets it evolve across the whole run, so add-with-carry and subtract-with-borrow see both values of C. Roughly one vector in seven drops flag enable, which shows that the flags hold while the combinational result keeps changing.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_LALT = 2'd3
   } size_e;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_ADC  = 4'd1,
      OP_SUB  = 4'd2,
      OP_SBC  = 4'd3,
      OP_BIC  = 4'd4,
      OP_BIS  = 4'd5,
      OP_XOR  = 4'd6,
      OP_BIT  = 4'd7,
      OP_CMP  = 4'd8,
      OP_MCOM = 4'd9,
      OP_MNEG = 4'd10,
      OP_CLR  = 4'd11,
      OP_INC  = 4'd12,
      OP_DEC  = 4'd13,
      OP_TST  = 4'd14,
      OP_NOP  = 4'd15
   } op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } ccodes_t;

   localparam int NUM_LANES = 3;

endpackage

// File: rtl/alu_addsub_lane.sv
module alu_addsub_lane #(
   parameter int W = 8
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         ovf
);

   if (W < 2) begin : g_bad_w
      $error("alu_addsub_lane: W must be at least 2");
   end

   logic [W:0] full;

   assign full = {1'b0, x} + {1'b0, y} + (W+1)'(cin);
   assign sum  = full[W-1:0];
   assign cout = full[W];
   // signed overflow: like-signed inputs giving an unlike-signed sum
   assign ovf  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
   import alu_pkg::*;
#(
   parameter int W = 32
) (
   input  op_e          op,
   input  logic [W-1:0] msk,
   input  logic [W-1:0] opnd,
   output logic [W-1:0] y
);

   always_comb begin
      unique case (op)
         OP_BIC:  y = opnd & ~msk;
         OP_BIS:  y = opnd | msk;
         OP_XOR:  y = opnd ^ msk;
         OP_BIT:  y = opnd & msk;
         OP_MCOM: y = ~msk;
         OP_TST:  y = msk;
         default: y = '0;
      endcase
   end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
   import alu_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    load,
   input  ccodes_t d,
   output ccodes_t q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (load)  q <= d;
   end

   // R12: flags keep their value on any edge without a load
   p_hold_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q))
      else $error("flags changed without load");

endmodule

// File: rtl/int_alu_cc.sv
module int_alu_cc
   import alu_pkg::*;
#(
   parameter int LONG_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LONG_W-1:0] opnd_a,
   input  logic [LONG_W-1:0] opnd_b,
   input  logic [1:0]        size_sel,
   input  logic [3:0]        op_sel,
   input  logic              flag_en,
   output logic [LONG_W-1:0] result,
   output logic              result_we,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_v,
   output logic              flag_c
);

   localparam int WORD_W = LONG_W / 2;
   localparam int BYTE_W = LONG_W / 4;
   localparam logic [LONG_W-1:0] MASK_B = {{(LONG_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
   localparam logic [LONG_W-1:0] MASK_W = {{(LONG_W-WORD_W){1'b0}}, {WORD_W{1'b1}}};
   localparam logic [LONG_W-1:0] MASK_L = {LONG_W{1'b1}};

   if (LONG_W < 8 || (LONG_W % 4) != 0) begin : g_bad_width
      $error("int_alu_cc: LONG_W must be a multiple of 4 and at least 8");
   end

   op_e               op;
   logic              long_only;
   logic [1:0]        lane_idx;
   logic [LONG_W-1:0] wmask;
   logic [LONG_W-1:0] add_x, add_y;
   logic              add_cin;
   logic              is_sub;
   logic [LONG_W-1:0] lane_sum [NUM_LANES];
   logic [NUM_LANES-1:0] lane_cout, lane_ovf;
   logic [LONG_W-1:0] add_sum;
   logic              add_cout, add_ovf;
   logic [LONG_W-1:0] logic_y;
   logic [LONG_W-1:0] raw, masked;
   logic              sign_bit;
   logic              is_arith;
   ccodes_t           cc_q, cc_d;
   logic              cc_load;

   assign op        = op_e'(op_sel);
   assign long_only = (op == OP_ADC) || (op == OP_SBC);

   // width lane select: carry-chained ops always use the full width
   always_comb begin
      if (long_only) lane_idx = 2'd2;
      else begin
         unique case (size_e'(size_sel))
            SZ_BYTE: lane_idx = 2'd0;
            SZ_WORD: lane_idx = 2'd1;
            default: lane_idx = 2'd2;
         endcase
      end
      unique case (lane_idx)
         2'd0:    wmask = MASK_B;
         2'd1:    wmask = MASK_W;
         default: wmask = MASK_L;
      endcase
   end

   // adder operand steering
   always_comb begin
      add_x   = '0;
      add_y   = '0;
      add_cin = 1'b0;
      is_sub  = 1'b0;
      is_arith = 1'b1;
      unique case (op)
         OP_ADD:  begin add_x = opnd_b; add_y = opnd_a; end
         OP_ADC:  begin add_x = opnd_b; add_y = opnd_a; add_cin = cc_q.c; end
         OP_SUB:  begin add_x = opnd_b; add_y = ~opnd_a; add_cin = 1'b1; is_sub = 1'b1; end
         OP_SBC:  begin add_x = opnd_b; add_y = ~opnd_a; add_cin = ~cc_q.c; is_sub = 1'b1; end
         OP_CMP:  begin add_x = opnd_a; add_y = ~opnd_b; add_cin = 1'b1; is_sub = 1'b1; end
         OP_MNEG: begin add_x = '0; add_y = ~opnd_a; add_cin = 1'b1; is_sub = 1'b1; end
         OP_INC:  begin add_x = opnd_a; add_y = LONG_W'(1); end
         OP_DEC:  begin add_x = opnd_a; add_y = ~LONG_W'(1); add_cin = 1'b1; is_sub = 1'b1; end
         default: is_arith = 1'b0;
      endcase
   end

   // one adder per operand width, so carry and overflow come from the right bit
   for (genvar s = 0; s < NUM_LANES; s++) begin : g_lane
      localparam int LW = LONG_W >> (NUM_LANES - 1 - s);
      logic [LW-1:0] s_sum;
      alu_addsub_lane #(.W(LW)) u_lane (
         .x    (add_x[LW-1:0]),
         .y    (add_y[LW-1:0]),
         .cin  (add_cin),
         .sum  (s_sum),
         .cout (lane_cout[s]),
         .ovf  (lane_ovf[s])
      );
      assign lane_sum[s] = LONG_W'(s_sum);
   end

   assign add_sum  = lane_sum[lane_idx];
   assign add_cout = lane_cout[lane_idx];
   assign add_ovf  = lane_ovf[lane_idx];

   alu_logic_unit #(.W(LONG_W)) u_logic (
      .op   (op),
      .msk  (opnd_a),
      .opnd (opnd_b),
      .y    (logic_y)
   );

   assign raw    = is_arith ? add_sum : logic_y;
   assign masked = raw & wmask;

   always_comb begin
      unique case (lane_idx)
         2'd0:    sign_bit = raw[BYTE_W-1];
         2'd1:    sign_bit = raw[WORD_W-1];
         default: sign_bit = raw[LONG_W-1];
      endcase
   end

   assign result_we = !((op == OP_BIT) || (op == OP_CMP) || (op == OP_TST) || (op == OP_NOP));
   assign result    = result_we ? masked : '0;

   // next flag values
   always_comb begin
      cc_d.n = sign_bit;
      cc_d.z = (masked == '0);
      cc_d.v = 1'b0;
      cc_d.c = cc_q.c;
      unique case (op)
         OP_ADD, OP_ADC, OP_INC, OP_SUB, OP_SBC, OP_MNEG, OP_DEC: begin
            cc_d.v = add_ovf;
            cc_d.c = is_sub ? ~add_cout : add_cout;
         end
         OP_CMP: begin
            cc_d.n = sign_bit ^ add_ovf;
            cc_d.c = ~add_cout;
         end
         OP_CLR: begin
            cc_d.n = 1'b0;
            cc_d.z = 1'b1;
         end
         OP_TST:  cc_d.c = 1'b0;
         default: ;
      endcase
   end

   assign cc_load = flag_en && (op != OP_NOP);

   alu_flag_reg u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (cc_load),
      .d     (cc_d),
      .q     (cc_q)
   );

   assign flag_n = cc_q.n;
   assign flag_z = cc_q.z;
   assign flag_v = cc_q.v;
   assign flag_c = cc_q.c;

   // R2: nothing leaks above the selected width
   p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_idx != 2'd2) |-> ((result & ~wmask) == '0))
      else $error("result bits above width");

   // R6: logical ops clear V and keep C
   p_logic_keeps_c_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_en && (op == OP_BIC || op == OP_BIS || op == OP_XOR))
      |=> (!flag_v && flag_c == $past(flag_c)))
      else $error("logical op disturbed V/C");

   // R7 and R8: bit test and compare present no result
   p_no_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_BIT || op == OP_CMP) |-> (result == '0 && !result_we))
      else $error("test/compare produced a result");

   // R8: equal operands compare as equal, not less
   p_cmp_equal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_en && op == OP_CMP && ((opnd_a ^ opnd_b) & wmask) == '0)
      |=> (flag_z && !flag_n && !flag_c && !flag_v))
      else $error("compare of equal operands");

   // R10: clear leaves N=0 Z=1 V=0 and C untouched
   p_clear_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_en && op == OP_CLR) |=> (flag_z && !flag_n && !flag_v && $stable(flag_c)))
      else $error("clear flags");

   // R12: the no-operation code never moves the flags
   p_nop_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_NOP) |=> $stable({flag_n, flag_z, flag_v, flag_c}))
      else $error("no-op changed flags");

endmodule

// File: tb/tb_int_alu_cc.sv
module tb_int_alu_cc;

   localparam int LW = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [LW-1:0] opnd_a, opnd_b;
   logic [1:0]    size_sel;
   logic [3:0]    op_sel;
   logic          flag_en;
   logic [LW-1:0] result;
   logic          result_we;
   logic          flag_n, flag_z, flag_v, flag_c;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   // model flags
   bit m_n = 0, m_z = 0, m_v = 0, m_c = 0;

   always #2 clk = ~clk;

   int_alu_cc #(.LONG_W(LW)) dut (
      .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .size_sel(size_sel), .op_sel(op_sel), .flag_en(flag_en),
      .result(result), .result_we(result_we),
      .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
   );

   task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic string req_of(int op);
      case (op)
         0:           return "R3";
         1, 3:        return "R5";
         2:           return "R4";
         4, 5, 6:     return "R6";
         7:           return "R7";
         8:           return "R8";
         9, 10:       return "R9";
         11:          return "R10";
         12, 13, 14:  return "R11";
         default:     return "R12";
      endcase
   endfunction

   function automatic logic [31:0] special(int k);
      case (k % 11)
         0: return 32'h0000_0000;
         1: return 32'h0000_0001;
         2: return 32'hFFFF_FFFF;
         3: return 32'h8000_0000;
         4: return 32'h7FFF_FFFF;
         5: return 32'h0000_0080;
         6: return 32'h0000_007F;
         7: return 32'h0000_8000;
         8: return 32'h0000_7FFF;
         9: return 32'h0000_00FF;
         default: return 32'h0000_FFFF;
      endcase
   endfunction

   // reference model computed arithmetically from the requirements
   task automatic model(input int op, input int sz, input longint a, input longint b,
                        input bit cin, output longint r, output bit we, output bit upd,
                        output bit en, output bit ez, output bit ev, output bit ec, output int w);
      longint mask, am, bm, sa, sb, lo, hi, u, t;
      bit arith;
      w    = (op == 1 || op == 3 || sz >= 2) ? 32 : (sz == 0 ? 8 : 16);
      mask = (longint'(1) << w) - 1;
      am = a & mask;  bm = b & mask;
      sa = (am >= (longint'(1) << (w-1))) ? am - (longint'(1) << w) : am;
      sb = (bm >= (longint'(1) << (w-1))) ? bm - (longint'(1) << w) : bm;
      lo = -(longint'(1) << (w-1));  hi = (longint'(1) << (w-1)) - 1;
      we = 1; upd = 1; ev = 0; ec = m_c; r = 0; arith = 0; u = 0; t = 0;
      case (op)
         0:  begin u = bm + am;            t = sb + sa;            arith = 1; end
         1:  begin u = bm + am + cin;      t = sb + sa + cin;      arith = 1; end
         2:  begin u = bm - am;            t = sb - sa;            arith = 1; end
         3:  begin u = bm - am - cin;      t = sb - sa - cin;      arith = 1; end
         4:  r = bm & ~am & mask;
         5:  r = bm | am;
         6:  r = bm ^ am;
         7:  begin r = bm & am; we = 0; end
         9:  r = ~am & mask;
         10: begin u = -am; t = -sa; arith = 1; end
         11: r = 0;
         12: begin u = am + 1; t = sa + 1; arith = 1; end
         13: begin u = am - 1; t = sa - 1; arith = 1; end
         14: begin r = am; we = 0; ec = 0; end
         default: ;
      endcase
      if (arith) begin
         r  = u & mask;
         ev = (t < lo) || (t > hi);
         if (op == 0 || op == 1 || op == 12) ec = ((u >> w) & 1) != 0;
         else if (op == 10)                  ec = (am != 0);
         else                                ec = (u < 0);
      end
      en = ((r >> (w-1)) & 1) != 0;
      ez = (r == 0);
      if (op == 8) begin
         we = 0; en = (sa < sb); ez = (am == bm); ec = (am < bm); ev = 0;
      end
      if (op == 15) begin
         we = 0; upd = 0;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] seed;
      seed = 32'h1234_5678;
      rst_n = 0; opnd_a = '0; opnd_b = '0; size_sel = '0; op_sel = 4'd15; flag_en = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1", "reset flags", {flag_n, flag_z, flag_v, flag_c}, 4'b0000);

      for (int op = 0; op < 16; op++) begin
         for (int sz = 0; sz < 4; sz++) begin
            for (int i = 0; i < 250; i++) begin
               logic [31:0] a, b;
               longint r;
               bit we, upd, en, ez, ev, ec, ld;
               int w;
               string tag;
               seed = seed * 32'd1664525 + 32'd1013904223;
               a = (i % 4 == 0) ? special(i / 4 + sz) : seed;
               seed = seed * 32'd1664525 + 32'd1013904223;
               b = (i % 5 == 0) ? a : ((i % 3 == 0) ? special(i + op) : seed);
               ld = (i % 7 != 3);
               @(negedge clk);
               opnd_a = a; opnd_b = b; size_sel = 2'(sz); op_sel = 4'(op); flag_en = ld;
               #1;
               model(op, sz, longint'(a), longint'(b), m_c, r, we, upd, en, ez, ev, ec, w);
               tag = req_of(op);
               check(tag, "result", result, we ? r : 0);
               check(tag, "write strobe", result_we, we);
               if (w < 32)
                  check("R2", "upper bits zero", result >> w, 0);
               @(posedge clk);
               #1;
               if (ld && upd) begin
                  m_n = en; m_z = ez; m_v = ev; m_c = ec;
               end
               if (!ld) tag = "R12";
               check(tag, "flags NZVC", {flag_n, flag_z, flag_v, flag_c}, {m_n, m_z, m_v, m_c});
            end
         end
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule